// File: doc/BRIEF.md
# Programmable Even Clock Divider Set

This block takes one crystal-rate source clock and derives three slower signals from it. The first is a reference tick, one source cycle wide, that repeats every R source cycles, where R is an 8-bit ratio. The second is a square-wave clock for an external microcontroller. The third is a square-wave switching clock for an on-chip dc-dc converter. Each of the two square waves divides the source by twice a programmed code. Each one ends in a toggle stage, so its duty cycle is exactly 50%.

A code of zero does not select a ratio. It turns the divided clock off and holds it low. The microcontroller clock also needs its enable bit set, and it is forced low during standby. The block also drives a VCO-enable status. This status drops when the converter is enabled but has no switching clock. A new nonzero code is picked up at the next toggle of the output it controls, so a reprogram never produces a shortened pulse. All control pins are plain levels with no handshake.

Top module: `clkdiv_set`

## Requirements
- R1: `ref_tick` is high for exactly one source cycle and repeats every `ref_ratio` source cycles, for `ref_ratio` from 2 to 255.
- R2: A `ref_ratio` of 0 or 1 behaves as a ratio of 2.
- R3: While running, `mcu_clk` has a period of 2×`buf_code` source cycles and stays high for `buf_code` cycles. The code is an unsigned 5-bit value, so the factor runs from 2 (code 1) to 62 (code 31).
- R4: A `buf_code` of 0 holds `mcu_clk` low from the next cycle onward, whatever the value of `buf_en`.
- R5: `mcu_clk` is held low from the next cycle onward when `buf_en` is 0 or `standby` is 1.
- R6: While running, `dcdc_clk` has a period of 2×`dcdc_code` source cycles and stays high for `dcdc_code` cycles. The code is an unsigned 7-bit value, so the factor runs from 2 to 254.
- R7: `dcdc_clk` is held low from the next cycle onward when `dcdc_en` is 0 or `dcdc_code` is 0.
- R8: `vco_en` is 0 in the cycle after one in which `dcdc_en` is 1 and `dcdc_code` is 0, and it is 1 after any other cycle.
- R9: When a nonzero code changes while its clock runs, the half period in progress finishes at the old length. Every later high and low run uses the new length, and no run of any other length appears.
- R10: During reset and right after it, `ref_tick`, `mcu_clk` and `dcdc_clk` are 0 and `vco_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Crystal-rate source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| standby | input | 1 | Standby; forces the microcontroller clock off |
| buf_en | input | 1 | Enable for the microcontroller clock output |
| dcdc_en | input | 1 | dc-dc converter enable |
| ref_ratio | input | 8 | Reference divide ratio R |
| buf_code | input | 5 | Microcontroller clock half-period code; 0 turns it off |
| dcdc_code | input | 7 | dc-dc clock half-period code; 0 turns it off |
| ref_tick | output | 1 | One-cycle reference tick every R cycles |
| mcu_clk | output | 1 | Divided microcontroller clock, 50% duty |
| dcdc_clk | output | 1 | Divided dc-dc switching clock, 50% duty |
| vco_en | output | 1 | VCO-enable status |

## Verification
The bench measures the period and the high time at the smallest and largest codes and at random codes in between. An off-by-one in the half counter would show up as a period of 2×code±2, or as a duty cycle other than 50%. For the reference ratios 0 and 1, a design without the clamp would either tick every cycle or stall. The bench reprograms a code in mid-period and checks every run length that follows, which catches a design that reloads at once and emits a runt pulse. It holds each gating condition (code 0 with the enable set, enable cleared, standby, converter disabled) for long stretches to catch any leak. It also checks `vco_en` against both the failing and the passing combinations of converter enable and code.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REF_W  = 8;
  localparam int BUF_W  = 5;
  localparam int DCDC_W = 7;
  localparam int REF_MIN = 2;

  function automatic logic [REF_W-1:0] clamp_ratio(input logic [REF_W-1:0] r);
    if (r < REF_W'(REF_MIN)) return REF_W'(REF_MIN);
    return r;
  endfunction
endpackage

// File: rtl/ref_divider.sv
module ref_divider
  import clkdiv_pkg::*;
#(
  parameter int RATIO_W = REF_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [RATIO_W-1:0] ratio,
  output logic               tick
);
  localparam int CW1 = RATIO_W + 1;

  logic [RATIO_W-1:0] cnt_q;
  logic [RATIO_W-1:0] r_eff;
  logic               at_end;

  always_comb begin
    r_eff  = (ratio < RATIO_W'(REF_MIN)) ? RATIO_W'(REF_MIN) : ratio;
    at_end = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, r_eff};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (at_end) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + RATIO_W'(1);
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/even_divider.sv
module even_divider #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              clk_out
);
  localparam int CW1 = CODE_W + 1;

  logic [CODE_W-1:0] cnt_q;
  logic [CODE_W-1:0] half_q;
  logic              active;
  logic              at_end;

  always_comb begin
    active = run && (code != '0);
    at_end = ({1'b0, cnt_q} + CW1'(1)) >= {1'b0, half_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      half_q  <= '0;
      clk_out <= 1'b0;
    end else if (!active) begin
      cnt_q   <= '0;
      half_q  <= code;
      clk_out <= 1'b0;
    end else if (half_q == '0) begin
      cnt_q  <= '0;
      half_q <= code;
    end else if (at_end) begin
      cnt_q   <= '0;
      half_q  <= code;
      clk_out <= ~clk_out;
    end else begin
      cnt_q <= cnt_q + CODE_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_set.sv
module clkdiv_set
  import clkdiv_pkg::*;
#(
  parameter int RW = REF_W,
  parameter int BW = BUF_W,
  parameter int DW = DCDC_W
) (
  input  logic          clk_src,
  input  logic          rst_n,
  input  logic          standby,
  input  logic          buf_en,
  input  logic          dcdc_en,
  input  logic [RW-1:0] ref_ratio,
  input  logic [BW-1:0] buf_code,
  input  logic [DW-1:0] dcdc_code,
  output logic          ref_tick,
  output logic          mcu_clk,
  output logic          dcdc_clk,
  output logic          vco_en
);
  logic buf_run;
  logic dcdc_starved;

  always_comb begin
    buf_run      = buf_en && !standby;
    dcdc_starved = dcdc_en && (dcdc_code == '0);
  end

  ref_divider #(.RATIO_W(RW)) u_ref (
    .clk(clk_src), .rst_n(rst_n), .ratio(ref_ratio), .tick(ref_tick)
  );

  even_divider #(.CODE_W(BW)) u_buf (
    .clk(clk_src), .rst_n(rst_n), .run(buf_run), .code(buf_code), .clk_out(mcu_clk)
  );

  even_divider #(.CODE_W(DW)) u_dcdc (
    .clk(clk_src), .rst_n(rst_n), .run(dcdc_en), .code(dcdc_code), .clk_out(dcdc_clk)
  );

  always_ff @(posedge clk_src) begin
    if (!rst_n) vco_en <= 1'b1;
    else        vco_en <= !dcdc_starved;
  end
endmodule

// File: rtl/clkdiv_set_chk.sv
module clkdiv_set_chk #(
  parameter int RW = 8,
  parameter int BW = 5,
  parameter int DW = 7
) (
  input logic          clk_src,
  input logic          rst_n,
  input logic          standby,
  input logic          buf_en,
  input logic          dcdc_en,
  input logic [RW-1:0] ref_ratio,
  input logic [BW-1:0] buf_code,
  input logic [DW-1:0] dcdc_code,
  input logic          ref_tick,
  input logic          mcu_clk,
  input logic          dcdc_clk,
  input logic          vco_en
);
  logic unused_ok;
  always_comb unused_ok = ^ref_ratio;

  AST_TICK_SINGLE: assert property (@(posedge clk_src) disable iff (!rst_n)
    ref_tick |=> !ref_tick); // R1
  AST_BUF_CODE_OFF: assert property (@(posedge clk_src) disable iff (!rst_n)
    (buf_code == '0) |=> !mcu_clk); // R4
  AST_BUF_GATED: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!buf_en || standby) |=> !mcu_clk); // R5
  AST_DCDC_OFF: assert property (@(posedge clk_src) disable iff (!rst_n)
    (!dcdc_en || dcdc_code == '0) |=> !dcdc_clk); // R7
  AST_VCO_LOW: assert property (@(posedge clk_src) disable iff (!rst_n)
    (dcdc_en && dcdc_code == '0) |=> !vco_en); // R8
  AST_VCO_HIGH: assert property (@(posedge clk_src) disable iff (!rst_n)
    !(dcdc_en && dcdc_code == '0) |=> vco_en); // R8
endmodule

bind clkdiv_set clkdiv_set_chk #(.RW(RW), .BW(BW), .DW(DW)) u_chk (.*);

// File: tb/tb_clkdiv_set.sv
module tb_clkdiv_set;
  logic       clk_src = 1'b0;
  logic       rst_n, standby, buf_en, dcdc_en;
  logic [7:0] ref_ratio;
  logic [4:0] buf_code;
  logic [6:0] dcdc_code;
  logic       ref_tick, mcu_clk, dcdc_clk, vco_en;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_src = ~clk_src;

  clkdiv_set dut (.*);

  function automatic logic pick(input int sel);
    case (sel)
      0:       return ref_tick;
      1:       return mcu_clk;
      default: return dcdc_clk;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // measures one full period starting at a rising edge, after skipping some rises
  task automatic measure(input int sel, input int skip, output int per, output int hi);
    logic prev, s;
    int   rises = 0;
    int   guard = 0;
    per = -1; hi = -1;
    prev = pick(sel);
    while (rises < skip + 1 && guard < 3000) begin
      @(negedge clk_src); guard++;
      s = pick(sel);
      if (!prev && s) rises++;
      prev = s;
    end
    if (rises < skip + 1) return;
    per = 1; hi = 1; guard = 0;
    forever begin
      @(negedge clk_src); guard++;
      s = pick(sel);
      if (!prev && s) break;
      if (guard > 3000) begin per = -1; hi = -1; return; end
      per++;
      if (s) hi++;
      prev = s;
    end
  endtask

  task automatic period_check(input string req, input int sel, input int exp_per, input int exp_hi);
    int per, hi;
    measure(sel, 1, per, hi);
    check({req, " period"}, per, exp_per);
    check({req, " high"}, hi, exp_hi);
  endtask

  task automatic stays_low(input string req, input int sel, input int cycles);
    int seen = 0;
    @(negedge clk_src);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_src);
      if (pick(sel)) seen++;
    end
    check(req, seen, 0);
  endtask

  // R9: after a code change, every run has the old or the new half length
  task automatic glitch_check(input int old_h, input int new_h);
    logic prev, s;
    int   len = 0;
    int   bad = 0;
    int   last = 0;
    int   runs = 0;
    int   guard = 0;
    prev = mcu_clk;
    while (runs < 8 && guard < 3000) begin
      @(negedge clk_src); guard++;
      s = mcu_clk;
      len++;
      if (s != prev) begin
        if (runs > 0 && len != old_h && len != new_h) bad++;
        last = len;
        runs++;
        len = 0;
      end
      prev = s;
    end
    check("R9 run lengths", bad, 0);
    check("R9 final run", last, new_h);
  endtask

  initial begin
    int r, c;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; standby = 1'b0; buf_en = 1'b1; dcdc_en = 1'b1;
    ref_ratio = 8'd4; buf_code = 5'd3; dcdc_code = 7'd5;
    repeat (4) @(negedge clk_src);
    check("R10 ref_tick", int'(ref_tick), 0);
    check("R10 mcu_clk", int'(mcu_clk), 0);
    check("R10 dcdc_clk", int'(dcdc_clk), 0);
    check("R10 vco_en", int'(vco_en), 1);
    rst_n = 1'b1;

    // R1 / R2 reference tick
    period_check("R1 ratio4", 0, 4, 1);
    ref_ratio = 8'd2;   period_check("R1 ratio2", 0, 2, 1);
    ref_ratio = 8'd255; period_check("R1 ratio255", 0, 255, 1);
    ref_ratio = 8'd0;   period_check("R2 ratio0", 0, 2, 1);
    ref_ratio = 8'd1;   period_check("R2 ratio1", 0, 2, 1);
    for (int i = 0; i < 3; i++) begin
      r = 2 + ($urandom % 254);
      ref_ratio = 8'(r);
      period_check("R1 random", 0, r, 1);
    end

    // R3 microcontroller clock
    period_check("R3 code3", 1, 6, 3);
    buf_code = 5'd1;  period_check("R3 code1", 1, 2, 1);
    buf_code = 5'd31; period_check("R3 code31", 1, 62, 31);
    for (int i = 0; i < 3; i++) begin
      c = 1 + ($urandom % 31);
      buf_code = 5'(c);
      period_check("R3 random", 1, 2 * c, c);
    end

    // R6 dc-dc clock
    period_check("R6 code5", 2, 10, 5);
    dcdc_code = 7'd1;   period_check("R6 code1", 2, 2, 1);
    dcdc_code = 7'd127; period_check("R6 code127", 2, 254, 127);
    for (int i = 0; i < 3; i++) begin
      c = 1 + ($urandom % 127);
      dcdc_code = 7'(c);
      period_check("R6 random", 2, 2 * c, c);
    end

    // R9 code change mid-period
    buf_code = 5'd5;
    period_check("R3 code5", 1, 10, 5);
    repeat (2) @(negedge clk_src);
    buf_code = 5'd9;
    glitch_check(5, 9);

    // R4 / R5 gating of the microcontroller clock
    buf_code = 5'd0; buf_en = 1'b1; stays_low("R4 code0 enabled", 1, 100);
    buf_code = 5'd2; buf_en = 1'b0; stays_low("R5 enable low", 1, 100);
    buf_en = 1'b1; standby = 1'b1;  stays_low("R5 standby", 1, 100);
    standby = 1'b0; period_check("R5 resume", 1, 4, 2);

    // R7 / R8 dc-dc gating and VCO status
    dcdc_code = 7'd0; dcdc_en = 1'b1;
    stays_low("R7 code0", 2, 50);
    check("R8 vco low", int'(vco_en), 0);
    dcdc_en = 1'b0;
    @(negedge clk_src);
    check("R8 vco high disabled", int'(vco_en), 1);
    dcdc_code = 7'd4;
    stays_low("R7 disabled", 2, 50);
    check("R8 vco high code4", int'(vco_en), 1);
    dcdc_en = 1'b1;
    period_check("R7 resume", 2, 8, 4);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_src);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule